// File: doc/BRIEF.md
# NAND Chip-Enable and Column Zone Controller

This block sits inside a NAND flash controller. It drives four active-low chip-enable lines and keeps the absolute column position for small-page devices, which hold 512 data bytes and 16 spare bytes per page. A chip-enable goes low either for the length of each command or, while a hold bit is set, continuously for the selected device. When the device is reselected under hold, the low level moves from the old device to the new one at a single clock edge.

The block also keeps the running flag of the data-transfer engine. Clearing the hold bit does not release the chip-enable directly. It asks the engine to stop once the byte in flight has finished, which is how a streaming transfer is aborted.

Read opcodes pick one of three zones: first half, second half or spare. The column given afterwards counts from the start of that zone. The block joins the two-bit zone extension and the relative column into an absolute column. It advances that column on each transferred byte and uses it to end the transfer at the last byte of the page. All pins are plain control and status signals. No data stream passes through the block, so no pin carries valid/ready flow control.

Top module: `nce_zone_ctrl`

## Requirements
- R1: After reset, all `ce_n` bits are 1, `running` is 0 and `col_abs` is 0.
- R2: When the hold bit is 1, the `ce_n` bit of the most recently accepted selected device is 0. Bit i belongs to device index i.
- R3: At every clock edge at most one `ce_n` bit is 0. A reselect while hold is 1 raises the old device's bit and lowers the new device's bit in the same cycle.
- R4: While hold is 0, the selected device's `ce_n` goes low in the cycle after `cmd_start` and stays low until the cycle after `cmd_done`. It also stays low while `running` is 1. If both strobes arrive in the same cycle, `cmd_start` wins.
- R5: Writing hold to 0 requests a stop and does not raise `ce_n` by itself. `running` clears on the next clock if `byte_busy` is 0. Otherwise it clears at the edge that samples `byte_strobe`.
- R6: On `opc_valid`, opcode 8'h00 sets the extension (`col_abs[9:8]`) to 2'b00, 8'h01 sets it to 2'b01 and 8'h50 sets it to 2'b10. Any other opcode leaves it unchanged.
- R7: `col_reg_acc` resets the extension to 2'b00 on the next clock. It takes priority over an opcode in the same cycle.
- R8: `col_abs` = {extension, relative column}. `col_load` loads the relative column from `col_rel`. Each `byte_strobe` while `running` is 1 adds one to `col_abs`, carrying from the relative column into the extension, provided `col_abs` is below 527 and no opcode, load or column-register access happens in that cycle.
- R9: A `byte_strobe` while `running` is 1 and `col_abs` is at least 527 clears `running`, and `col_abs` holds its value.
- R10: A select whose device index is greater than `max_dev` is ignored, unless `card_en` is 1 and the index is 3 (the removable-card slot).
- R11: `xfer_start` sets `running` on the next clock. A hold-clear write in the same cycle wins, and `running` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_en | input | 1 | Enables device index 3 as the card slot |
| max_dev | input | 2 | Highest device index that is accepted normally |
| sel_valid | input | 1 | Device-select action strobe |
| sel_dev | input | 2 | Device index for the select action |
| hold_we | input | 1 | Write strobe for the hold bit |
| hold_d | input | 1 | Value written to the hold bit |
| cmd_start | input | 1 | A command begins |
| cmd_done | input | 1 | The command has completed |
| opc_valid | input | 1 | Read opcode strobe |
| opc | input | 8 | Read opcode |
| col_reg_acc | input | 1 | Column register read or write |
| col_load | input | 1 | Load the relative column |
| col_rel | input | 8 | Relative column value |
| xfer_start | input | 1 | Start the data transfer engine |
| byte_busy | input | 1 | A byte transfer is in flight |
| byte_strobe | input | 1 | A byte transfer completes |
| ce_n | output | 4 | Active-low chip enables |
| col_abs | output | 10 | Absolute column |
| running | output | 1 | Transfer engine running flag |

## Verification
The chip-enable logic is tried in three ways: under hold with back-to-back reselects, with bare command strobes, and with transfers that keep the enable low after hold is cleared. Together these show whether the enable follows hold, command state or running state. Zone tracking uses each of the three zone opcodes, an unknown opcode, a column-register access that collides with an opcode, and a transfer that crosses from the first half into the second. Separate runs reach column 527 in the spare zone and stop a transfer with and without a byte in flight, which shows whether `running` clears for the right reason and at the right edge. A long run of mixed random stimulus then checks every output against the reference model on every cycle.

// File: rtl/nce_pkg.sv
package nce_pkg;

  typedef enum logic [1:0] {
    ZONE_FIRST  = 2'b00,
    ZONE_SECOND = 2'b01,
    ZONE_SPARE  = 2'b10
  } zone_e;

  localparam logic [7:0] OPC_FIRST  = 8'h00;
  localparam logic [7:0] OPC_SECOND = 8'h01;
  localparam logic [7:0] OPC_SPARE  = 8'h50;

  function automatic logic opc_hits_zone(input logic [7:0] op);
    return (op == OPC_FIRST) || (op == OPC_SECOND) || (op == OPC_SPARE);
  endfunction

  function automatic zone_e opc_zone(input logic [7:0] op);
    zone_e z;
    case (op)
      OPC_SECOND: z = ZONE_SECOND;
      OPC_SPARE:  z = ZONE_SPARE;
      default:    z = ZONE_FIRST;
    endcase
    return z;
  endfunction

endpackage

// File: rtl/nce_select.sv
module nce_select #(
  parameter int NUM_DEV  = 4,
  parameter int DEV_W    = 2,
  parameter int CARD_DEV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               card_en,
  input  logic [DEV_W-1:0]   max_dev,
  input  logic               sel_valid,
  input  logic [DEV_W-1:0]   sel_dev,
  input  logic               hold_we,
  input  logic               hold_d,
  input  logic               cmd_start,
  input  logic               cmd_done,
  input  logic               xfer_live,
  output logic [NUM_DEV-1:0] ce_n
);

  logic             hold_q;
  logic             cmd_q;
  logic [DEV_W-1:0] dev_q;
  logic             accept;
  logic             engage;

  assign accept = sel_valid &&
                  ((sel_dev <= max_dev) || (card_en && sel_dev == DEV_W'(CARD_DEV)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cmd_q  <= 1'b0;
      dev_q  <= '0;
    end else begin
      if (hold_we)        hold_q <= hold_d;
      if (cmd_start)      cmd_q  <= 1'b1;
      else if (cmd_done)  cmd_q  <= 1'b0;
      if (accept)         dev_q  <= sel_dev;
    end
  end

  assign engage = hold_q || cmd_q || xfer_live;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_ce
    assign ce_n[g] = ~(engage && (dev_q == DEV_W'(g)));
  end

  assert_one_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));

  assert_hold_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && accept && !(hold_we && !hold_d))
    |=> (ce_n == ~({{(NUM_DEV-1){1'b0}}, 1'b1} << $past(sel_dev))));

  assert_ignore_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !accept) |=> $stable(dev_q));

  assert_cmd_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (ce_n[dev_q] == 1'b0));

endmodule

// File: rtl/nce_zone.sv
module nce_zone
  import nce_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int EXT_W     = 2,
  parameter int PAGE_LAST = 527,
  localparam int ABS_W    = COL_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_reg_acc,
  input  logic             opc_valid,
  input  logic [7:0]       opc,
  input  logic             col_load,
  input  logic [COL_W-1:0] col_rel,
  input  logic             step,
  output logic [ABS_W-1:0] col_abs,
  output logic             at_end
);

  logic [ABS_W-1:0] col_q;
  logic [ABS_W-1:0] col_inc;
  logic [EXT_W-1:0] ext_d;
  logic [COL_W-1:0] rel_d;
  logic             advance;
  logic             opc_hit;

  assign at_end  = col_q >= ABS_W'(PAGE_LAST);
  assign opc_hit = opc_valid && opc_hits_zone(opc);
  assign advance = step && !at_end && !col_reg_acc && !opc_valid && !col_load;
  assign col_inc = col_q + ABS_W'(1);

  always_comb begin
    ext_d = col_q[ABS_W-1:COL_W];
    rel_d = col_q[COL_W-1:0];
    if (advance) begin
      ext_d = col_inc[ABS_W-1:COL_W];
      rel_d = col_inc[COL_W-1:0];
    end else begin
      if (col_reg_acc)  ext_d = '0;
      else if (opc_hit) ext_d = EXT_W'(opc_zone(opc));
      if (col_load)     rel_d = col_rel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= {ext_d, rel_d};
  end

  assign col_abs = col_q;

  assert_ext_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_reg_acc |=> (col_abs[ABS_W-1:COL_W] == '0));

  assert_spare_opc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_valid && opc == OPC_SPARE && !col_reg_acc) |=> (col_abs[ABS_W-1:COL_W] == EXT_W'(ZONE_SPARE)));

  assert_step_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_end && !col_reg_acc && !opc_valid && !col_load)
    |=> (col_abs == $past(col_abs) + ABS_W'(1)));

  assert_end_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !col_reg_acc && !opc_valid && !col_load) |=> $stable(col_abs));

endmodule

// File: rtl/nce_runner.sv
module nce_runner (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic hold_we,
  input  logic hold_d,
  input  logic byte_busy,
  input  logic byte_strobe,
  input  logic at_end,
  output logic running
);

  logic run_q;
  logic pend_q;
  logic stop_wr;
  logic stop_req;
  logic finish;
  logic run_d;

  assign stop_wr  = hold_we && !hold_d;
  assign stop_req = pend_q || stop_wr;
  assign finish   = run_q && ((stop_req && (!byte_busy || byte_strobe)) ||
                              (byte_strobe && at_end));

  always_comb begin
    run_d = run_q;
    if (finish)                     run_d = 1'b0;
    else if (xfer_start && !stop_wr) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pend_q <= run_d && stop_req;
    end
  end

  assign running = run_q;

  assert_page_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && byte_strobe && at_end) |=> !running);

  assert_idle_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !byte_busy) |=> !running);

  assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && xfer_start && !stop_wr) |=> running);

endmodule

// File: rtl/nce_zone_ctrl.sv
module nce_zone_ctrl #(
  parameter int NUM_DEV   = 4,
  parameter int COL_W     = 8,
  parameter int EXT_W     = 2,
  parameter int PAGE_LAST = 527,
  localparam int DEV_W    = $clog2(NUM_DEV),
  localparam int ABS_W    = COL_W + EXT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               card_en,
  input  logic [DEV_W-1:0]   max_dev,
  input  logic               sel_valid,
  input  logic [DEV_W-1:0]   sel_dev,
  input  logic               hold_we,
  input  logic               hold_d,
  input  logic               cmd_start,
  input  logic               cmd_done,
  input  logic               opc_valid,
  input  logic [7:0]         opc,
  input  logic               col_reg_acc,
  input  logic               col_load,
  input  logic [COL_W-1:0]   col_rel,
  input  logic               xfer_start,
  input  logic               byte_busy,
  input  logic               byte_strobe,
  output logic [NUM_DEV-1:0] ce_n,
  output logic [ABS_W-1:0]   col_abs,
  output logic               running
);

  logic at_end;
  logic step;

  assign step = byte_strobe && running;

  nce_select #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .CARD_DEV(NUM_DEV-1)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_en   (card_en),
    .max_dev   (max_dev),
    .sel_valid (sel_valid),
    .sel_dev   (sel_dev),
    .hold_we   (hold_we),
    .hold_d    (hold_d),
    .cmd_start (cmd_start),
    .cmd_done  (cmd_done),
    .xfer_live (running),
    .ce_n      (ce_n)
  );

  nce_zone #(.COL_W(COL_W), .EXT_W(EXT_W), .PAGE_LAST(PAGE_LAST)) u_zone (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_reg_acc (col_reg_acc),
    .opc_valid   (opc_valid),
    .opc         (opc),
    .col_load    (col_load),
    .col_rel     (col_rel),
    .step        (step),
    .col_abs     (col_abs),
    .at_end      (at_end)
  );

  nce_runner u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_start  (xfer_start),
    .hold_we     (hold_we),
    .hold_d      (hold_d),
    .byte_busy   (byte_busy),
    .byte_strobe (byte_strobe),
    .at_end      (at_end),
    .running     (running)
  );

  assert_run_keeps_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ce_n != {NUM_DEV{1'b1}}));

endmodule

// File: tb/sim_nce_zone_ctrl.sv
`timescale 1ns/1ps
module sim_nce_zone_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_en = 1'b0;
  logic [1:0] max_dev = 2'd3;
  logic       sel_valid = 1'b0;
  logic [1:0] sel_dev = 2'd0;
  logic       hold_we = 1'b0, hold_d = 1'b0;
  logic       cmd_start = 1'b0, cmd_done = 1'b0;
  logic       opc_valid = 1'b0;
  logic [7:0] opc = 8'h00;
  logic       col_reg_acc = 1'b0, col_load = 1'b0;
  logic [7:0] col_rel = 8'h00;
  logic       xfer_start = 1'b0, byte_busy = 1'b0, byte_strobe = 1'b0;
  logic [3:0] ce_n;
  logic [9:0] col_abs;
  logic       running;

  always #4 clk = ~clk;

  nce_zone_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .card_en(card_en), .max_dev(max_dev),
    .sel_valid(sel_valid), .sel_dev(sel_dev), .hold_we(hold_we), .hold_d(hold_d),
    .cmd_start(cmd_start), .cmd_done(cmd_done), .opc_valid(opc_valid), .opc(opc),
    .col_reg_acc(col_reg_acc), .col_load(col_load), .col_rel(col_rel),
    .xfer_start(xfer_start), .byte_busy(byte_busy), .byte_strobe(byte_strobe),
    .ce_n(ce_n), .col_abs(col_abs), .running(running)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_hold = 0, m_dev = 0, m_cmd = 0, m_run = 0, m_pend = 0, m_col = 0;

  task automatic model_step();
    int ext, rel, nrun;
    bit accept, stopw, stopreq, clr, adv;
    accept  = sel_valid && (sel_dev <= max_dev || (card_en && sel_dev == 2'd3));
    stopw   = hold_we && !hold_d;
    stopreq = (m_pend != 0) || stopw;
    clr     = (m_run != 0) && ((stopreq && (!byte_busy || byte_strobe)) ||
                               (byte_strobe && m_col >= 527));
    adv     = byte_strobe && (m_run != 0) && m_col < 527 &&
              !col_reg_acc && !opc_valid && !col_load;
    nrun = clr ? 0 : ((xfer_start && !stopw) ? 1 : m_run);
    m_pend = (nrun != 0 && stopreq) ? 1 : 0;
    m_run  = nrun;
    if (adv) m_col = m_col + 1;
    else begin
      ext = m_col / 256;
      rel = m_col % 256;
      if (col_reg_acc) ext = 0;
      else if (opc_valid && opc == 8'h00) ext = 0;
      else if (opc_valid && opc == 8'h01) ext = 1;
      else if (opc_valid && opc == 8'h50) ext = 2;
      if (col_load) rel = int'(col_rel);
      m_col = ext * 256 + rel;
    end
    if (cmd_start) m_cmd = 1;
    else if (cmd_done) m_cmd = 0;
    if (hold_we) m_hold = hold_d ? 1 : 0;
    if (accept) m_dev = int'(sel_dev);
  endtask

  task automatic compare(string tag);
    logic [3:0] exp_ce;
    exp_ce = 4'hF;
    if (m_hold != 0 || m_cmd != 0 || m_run != 0) exp_ce[m_dev] = 1'b0;
    n_cmp += 3;
    if (ce_n !== exp_ce) begin
      n_bad++; $display("FAIL %s ce_n actual=%b expected=%b t=%0t", tag, ce_n, exp_ce, $time);
    end
    if (running !== (m_run != 0)) begin
      n_bad++; $display("FAIL %s running actual=%b expected=%0d t=%0t", tag, running, m_run, $time);
    end
    if (col_abs !== 10'(m_col)) begin
      n_bad++; $display("FAIL %s col_abs actual=%0d expected=%0d t=%0t", tag, col_abs, m_col, $time);
    end
  endtask

  task automatic idle();
    sel_valid = 0; hold_we = 0; cmd_start = 0; cmd_done = 0; opc_valid = 0;
    col_reg_acc = 0; col_load = 0; xfer_start = 0; byte_strobe = 0;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  task automatic sel(input logic [1:0] d);
    sel_valid = 1; sel_dev = d;
  endtask

  task automatic hold(input logic v);
    hold_we = 1; hold_d = v;
  endtask

  task automatic op(input logic [7:0] c);
    opc_valid = 1; opc = c;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    // R2: select then hold
    sel(2'd1); tick("R2");
    hold(1); tick("R2");
    tick("R2");
    // R3: reselect under hold
    sel(2'd2); tick("R3");
    sel(2'd0); tick("R3");
    // R10: out-of-range selects
    max_dev = 2'd1; card_en = 0;
    sel(2'd3); tick("R10");
    sel(2'd2); tick("R10");
    card_en = 1;
    sel(2'd3); tick("R10");
    max_dev = 2'd3;
    // R5: hold clear with nothing running
    hold(0); tick("R5");
    tick("R5");
    // R4: command strobes
    sel(2'd1); tick("R4");
    cmd_start = 1; tick("R4");
    tick("R4");
    cmd_done = 1; tick("R4");
    cmd_start = 1; cmd_done = 1; tick("R4");
    cmd_done = 1; tick("R4");
    // R6: opcodes
    op(8'h01); tick("R6");
    op(8'h3C); tick("R6");
    op(8'h50); tick("R6");
    op(8'h00); tick("R6");
    // R7: column register access beats opcode
    op(8'h01); tick("R7");
    col_reg_acc = 1; op(8'h50); tick("R7");
    // R8: crossing 255 -> 256
    col_load = 1; col_rel = 8'd253; tick("R8");
    xfer_start = 1; tick("R11");
    for (int i = 0; i < 5; i++) begin byte_strobe = 1; tick("R8"); end
    col_load = 1; col_rel = 8'd9; byte_strobe = 1; tick("R8");
    // R9: spare zone to the end
    op(8'h50); tick("R9");
    col_load = 1; col_rel = 8'd12; tick("R9");
    for (int i = 0; i < 6; i++) begin byte_strobe = 1; tick("R9"); end
    byte_strobe = 1; tick("R9");
    // R11: start with simultaneous stop write
    xfer_start = 1; hold(0); tick("R11");
    // R5: stop with a byte in flight, hold set keeps ce
    hold(1); xfer_start = 1; tick("R5");
    byte_busy = 1;
    hold(0); tick("R5");
    tick("R5");
    byte_strobe = 1; tick("R5");
    byte_busy = 0; tick("R5");
    // mixed random run, every output against the model (R3 one-hot)
    for (int i = 0; i < 3000; i++) begin
      sel_valid   = ($urandom_range(0, 7) == 0);
      sel_dev     = 2'($urandom_range(0, 3));
      max_dev     = 2'($urandom_range(0, 3));
      card_en     = 1'($urandom_range(0, 1));
      hold_we     = ($urandom_range(0, 9) == 0);
      hold_d      = 1'($urandom_range(0, 1));
      cmd_start   = ($urandom_range(0, 9) == 0);
      cmd_done    = ($urandom_range(0, 9) == 0);
      opc_valid   = ($urandom_range(0, 19) == 0);
      opc         = ($urandom_range(0, 3) == 0) ? 8'h77 : 8'($urandom_range(0, 1) * 8'h50 + 8'($urandom_range(0, 1)));
      col_reg_acc = ($urandom_range(0, 39) == 0);
      col_load    = ($urandom_range(0, 29) == 0);
      col_rel     = 8'($urandom_range(0, 255));
      xfer_start  = ($urandom_range(0, 9) == 0);
      byte_busy   = 1'($urandom_range(0, 1));
      byte_strobe = 1'($urandom_range(0, 1));
      tick("R3");
    end
    finish_run();
  end

endmodule